// File: doc/BRIEF.md
# Framed Three-Bit Pattern Recognizer

This block watches a serial bit stream, one bit per qualified clock cycle, and cuts it into back-to-back groups of three bits. The groups never overlap: the fourth accepted bit after reset always opens a new group, whatever the previous group held. On the third bit of every group the Mealy output `hit` reports, in the same cycle as that bit, whether the group arrived as 0, then 0, then 1.

Cycles with `bit_vld` low carry no data. They do not move the group position. A synchronous reset places the machine at the start of a group, so the first bit accepted after reset is the first bit of a group.

The parameter `PAD_ZERO` picks one of two implementations. With `PAD_ZERO = 1`, a position counter tracks the place within the group, and `hit` is held at 0 on the first and second bits. With `PAD_ZERO = 0`, the block is the reduced three-state machine. It stores only how many zeros were seen most recently, uses the don't-care outputs on the first and second bits freely, and may raise `hit` there.

Top module: `trip_detect`

## Requirements
- R1: While `rst` is high, `hit` is 0. The first bit accepted after `rst` falls is the first bit of a group, including when the reset arrives partway through a group.
- R2: On the third accepted bit of a group, `hit` is 1 in that same cycle when the group arrived as bit values 0, 0, 1 in arrival order.
- R3: On the third accepted bit of any other group, `hit` is 0.
- R4: Groups are consecutive and non-overlapping. A 0, 0, 1 pattern that spans a group boundary produces no `hit` on a group's third bit, and with `PAD_ZERO = 1` it produces no `hit` at all.
- R5: A cycle with `bit_vld` low leaves the group position and the match progress unchanged, and `hit` is 0 in that cycle.
- R6: With `PAD_ZERO = 1`, `hit` is 0 on the first and second accepted bits of every group.
- R7: With `PAD_ZERO = 0`, the machine uses exactly three states and meets R2 and R3 on third bits. Its output on first and second bits is unspecified.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; returns the machine to a group start |
| bit_vld | input | 1 | High when `bit_in` carries a stream bit this cycle |
| bit_in | input | 1 | Serial data bit |
| hit | output | 1 | Mealy match flag, meaningful on the third bit of a group |

## Verification
The bench builds two copies of the block and drives them with the same stream: one with `PAD_ZERO = 1` and one with `PAD_ZERO = 0`. The padded copy makes every accepted bit checkable, because its first- and second-bit outputs must be 0. The reduced copy exposes whether the three merged states still give the right verdict on third bits, even where a pattern spans a group boundary. Long random streams with idle gaps and a zero-heavy bias reach both matching and near-miss groups. Directed sequences cover resets in the middle of a group and patterns that straddle group boundaries.

// File: rtl/trip_pkg.sv
package trip_pkg;

    localparam int GROUP_LEN = 3;
    localparam int PHASE_W   = $clog2(GROUP_LEN);
    localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(GROUP_LEN - 1);

    // Reduced machine classes: how many zeros in a row were just seen.
    typedef enum logic [1:0] {
        CLS_START    = 2'b00,
        CLS_ONE_ZERO = 2'b01,
        CLS_TWO_ZERO = 2'b10
    } cls_e;

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic               live;
    } frame_t;

    function automatic cls_e cls_next(cls_e cur, logic b);
        if (b) return CLS_START;
        case (cur)
            CLS_START:    return CLS_ONE_ZERO;
            CLS_ONE_ZERO: return CLS_TWO_ZERO;
            default:      return CLS_TWO_ZERO;
        endcase
    endfunction

    function automatic logic cls_out(cls_e cur, logic b);
        return (cur == CLS_TWO_ZERO) && b;
    endfunction

endpackage

// File: rtl/trip_phase.sv
module trip_phase
    import trip_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               adv,
    output logic [PHASE_W-1:0] phase,
    output logic               last
);
    logic [PHASE_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (adv)
            phase_q <= (phase_q == LAST_PHASE) ? '0 : phase_q + 1'b1;
    end

    assign phase = phase_q;
    assign last  = (phase_q == LAST_PHASE);

    // R5: idle cycles keep the position
    a_r5_phase_hold: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(phase_q));

    // R4: after the third bit the next group starts at position 0
    a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && last) |=> (phase_q == '0));
endmodule

// File: rtl/trip_framed_core.sv
module trip_framed_core
    import trip_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               adv,
    input  logic               b,
    input  logic [PHASE_W-1:0] phase,
    input  logic               last,
    output logic               hit
);
    frame_t st_q;
    logic   live_d;

    always_comb begin
        if (phase == '0)
            live_d = ~b;
        else
            live_d = st_q.live & ~b;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '{phase: '0, live: 1'b0};
        else if (adv)
            st_q <= '{phase: phase, live: live_d};
    end

    assign hit = adv && last && st_q.live && b;

    // R6: a hit is only ever raised on the last position of a group
    a_r6_hit_on_last: assert property (@(posedge clk) disable iff (rst)
        hit |-> last);
endmodule

// File: rtl/trip_reduced_core.sv
module trip_reduced_core
    import trip_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic b,
    output logic hit
);
    cls_e cls_q;

    always_ff @(posedge clk) begin
        if (rst)
            cls_q <= CLS_START;
        else if (adv)
            cls_q <= cls_next(cls_q, b);
    end

    assign hit = adv && cls_out(cls_q, b);

    // R5: idle cycles keep the class
    a_r5_cls_hold: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cls_q));

    // R7: only three states are ever occupied
    a_r7_three_states: assert property (@(posedge clk) disable iff (rst)
        cls_q != 2'b11);

    // R7: any accepted one returns the machine to the start class
    a_r7_one_restarts: assert property (@(posedge clk) disable iff (rst)
        (adv && b) |=> (cls_q == CLS_START));
endmodule

// File: rtl/trip_detect.sv
module trip_detect
    import trip_pkg::*;
#(
    parameter bit PAD_ZERO = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic bit_in,
    output logic hit
);
    logic core_hit;

    generate
        if (PAD_ZERO) begin : g_framed
            logic [PHASE_W-1:0] phase;
            logic               last;

            trip_phase u_phase (
                .clk   (clk),
                .rst   (rst),
                .adv   (bit_vld),
                .phase (phase),
                .last  (last)
            );

            trip_framed_core u_core (
                .clk   (clk),
                .rst   (rst),
                .adv   (bit_vld),
                .b     (bit_in),
                .phase (phase),
                .last  (last),
                .hit   (core_hit)
            );
        end else begin : g_reduced
            trip_reduced_core u_core (
                .clk (clk),
                .rst (rst),
                .adv (bit_vld),
                .b   (bit_in),
                .hit (core_hit)
            );
        end
    endgenerate

    assign hit = core_hit & ~rst;

    // R2: a hit is only raised on an accepted one
    a_r2_hit_on_one: assert property (@(posedge clk) disable iff (rst)
        hit |-> (bit_vld && bit_in));
endmodule

// File: tb/trip_detect_tb.sv
module trip_detect_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vld = 1'b0;
    logic din = 1'b0;
    logic hit_pad, hit_min;

    always #(CLK_PERIOD/2) clk = ~clk;

    trip_detect #(.PAD_ZERO(1'b1)) u_dut (
        .clk(clk), .rst(rst), .bit_vld(vld), .bit_in(din), .hit(hit_pad));

    trip_detect #(.PAD_ZERO(1'b0)) u_dut_min (
        .clk(clk), .rst(rst), .bit_vld(vld), .bit_in(din), .hit(hit_min));

    typedef struct {
        int    pos;
        logic  exp;
        string note;
    } item_t;

    item_t q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    int    pos    = 0;
    logic  f0 = 1'b0, f1 = 1'b0;
    string note = "";
    bit    done = 1'b0;

    task automatic check(string req, string who, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, who, act, exp);
        end
    endtask

    // Driver: presents one cycle and queues the expected result of an accepted bit.
    task automatic send(logic v, logic b);
        item_t it;
        @(posedge clk);
        #1;
        vld = v;
        din = b;
        if (v && !rst) begin
            it.pos  = pos;
            it.note = note;
            it.exp  = (pos == 2) && !f0 && !f1 && b;
            if (pos == 0) f0 = b;
            if (pos == 1) f1 = b;
            q.push_back(it);
            pos = (pos + 1) % 3;
        end
    endtask

    task automatic bits3(logic a, logic b, logic c);
        send(1'b1, a);
        send(1'b1, b);
        send(1'b1, c);
    endtask

    task automatic do_reset(int cycles);
        @(posedge clk);
        #1;
        rst = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            vld = 1'b1;
            din = i[0];
            @(posedge clk);
            #1;
        end
        rst = 1'b0;
        vld = 1'b0;
        pos = 0;
    endtask

    // Monitor: compares at the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            if (rst) begin
                check("R1", "pad", hit_pad, 1'b0);
                check("R1", "min", hit_min, 1'b0);
            end else if (vld) begin
                if (q.size() == 0) begin
                    check("R5", "queue", 1'b1, 1'b0);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    if (it.pos == 2) begin
                        check(it.exp ? {"R2 ", it.note} : {"R3 ", it.note}, "pad", hit_pad, it.exp);
                        check({"R7 ", it.note}, "min", hit_min, it.exp);
                    end else begin
                        check({"R6 ", it.note}, "pad", hit_pad, 1'b0);
                    end
                end
            end else begin
                check("R5", "pad", hit_pad, 1'b0);
                check("R5", "min", hit_min, 1'b0);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset with live input, then a matching group right after
        do_reset(3);
        note = "R1";
        bits3(1'b0, 1'b0, 1'b1);
        // R2 / R3 basic groups
        note = "";
        bits3(1'b0, 1'b0, 1'b0);
        bits3(1'b1, 1'b0, 1'b1);
        bits3(1'b0, 1'b0, 1'b1);
        bits3(1'b0, 1'b1, 1'b1);
        // R4: patterns spanning boundaries (x00|1xx and x x0|01x)
        note = "R4";
        bits3(1'b1, 1'b0, 1'b0);
        bits3(1'b1, 1'b1, 1'b0);
        bits3(1'b0, 1'b1, 1'b0);
        bits3(1'b0, 1'b0, 1'b1);
        // R5: idle gaps inside a group with a pending match
        note = "R5";
        send(1'b1, 1'b0);
        send(1'b0, 1'b1);
        send(1'b0, 1'b1);
        send(1'b1, 1'b0);
        send(1'b0, 1'b0);
        send(1'b1, 1'b1);
        // R1: reset in the middle of a group realigns groups
        note = "R1";
        send(1'b1, 1'b0);
        do_reset(2);
        bits3(1'b0, 1'b0, 1'b1);
        send(1'b1, 1'b1);
        send(1'b1, 1'b0);
        do_reset(1);
        bits3(1'b0, 1'b0, 1'b1);
        // Random streams with idle gaps and a zero bias
        note = "rand";
        for (int i = 0; i < 4000; i++) begin
            send(($urandom % 4) != 0, ($urandom % 3) == 0);
        end
        send(1'b0, 1'b0);
        send(1'b0, 1'b0);
        finish_run();
    end
endmodule